// File: doc/BRIEF.md
# Call-gate privilege transfer sequencer

This block carries out a far call through a call gate and the matching far return for a small protected-mode core. The caller supplies a gate descriptor that has already been fetched, the current code and stack registers (CS, IP, SS, SP), the privilege level of the target code segment, and the selector and width of the task-state segment. The block first validates the gate. When the call moves inward to a more privileged ring, it fetches that ring's stack pair from the task-state segment and builds a frame on the new stack: the old stack pair, a counted number of parameters copied from the old stack, and the return address. When the call stays at the same ring, it pushes only the return address on the current stack.

All memory traffic uses one request/acknowledge port that addresses a segment selector plus a byte offset. Resolving the selector to a linear address is left to the environment. Each transfer is 2 or 4 bytes wide and little-endian. The far return pops the return address, discards an optional byte count, and pops the outer stack pair when control goes back to a less privileged ring. The resulting CS, IP, SS and SP appear on registered outputs together with a one-cycle done pulse.

Top module: `gate_xfer_seq`

## Requirements
- R1: The gate descriptor fields are read from fixed positions. Entry offset low half is bits 15:0 and high half is bits 63:48. Target code selector is bits 31:16. Parameter count is bits 36:32. Type is bits 43:40. DPL is bits 46:45. The present flag is bit 47.
- R2: A call request faults when any of these holds: the type is neither 4'h4 (16-bit gate) nor 4'hC (32-bit gate), the present flag is 0, the current level CS[1:0] is numerically above the DPL, or the target level is numerically above the current level. On a fault, `fault` pulses for one cycle in the cycle after the request. No memory access is made, no done pulse is issued, and out_cs, out_ip, out_ss and out_sp keep their values.
- R3: An inward call (target level below the current level) reads the new SP and then the new SS from the task-state segment at selector tss_sel. With tss_wide=1 the offsets are SP at 4+8n (4 bytes) and SS at 8+8n. With tss_wide=0 they are SP at 2+4n (2 bytes) and SS at 4+4n. Here n is the target ring.
- R4: An inward call pushes, in order, the old SS, the old SP, the parameters, the old CS and the old IP onto the new stack. Each slot is 4 bytes for a 32-bit gate and 2 bytes for a 16-bit gate. SP is decremented by the slot size before each write.
- R5: The parameter count gives the number of slots copied from the old stack to the new one. Word order is preserved: the slot at old SP+i*w lands at new frame position i above the last copied slot.
- R6: On a successful call, out_cs takes the gate selector with bits 1:0 replaced by the target level. out_ip takes the entry offset, using only the low half for a 16-bit gate. out_ss and out_sp take the final stack pair.
- R7: A call at the same level makes no task-state read and copies no parameters. It pushes CS and then IP on the current stack and keeps SS.
- R8: A far return pops IP and then CS from the current stack, then adds ret_bytes to SP. If the popped CS[1:0] is above the current level, it next pops SP and then SS. Otherwise SS is kept and SP is left past the discarded bytes. Slot width follows ret_wide.
- R9: `busy` is high from the cycle after an accepted request until the final load. `done` is high for exactly one cycle, in the cycle the new register values first appear, and never together with `busy`. A memory request keeps its address and direction steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| call_req | input | 1 | Start a far call through gate_desc |
| ret_req | input | 1 | Start a far return |
| gate_desc | input | 64 | Fetched call-gate descriptor |
| tgt_pl | input | 2 | Privilege level of the target code segment |
| tss_sel | input | 16 | Selector of the task-state segment |
| tss_wide | input | 1 | 1: 32-bit task-state layout, 0: 16-bit |
| ret_wide | input | 1 | Return slot width, 1: 4 bytes, 0: 2 bytes |
| ret_bytes | input | 16 | Parameter bytes discarded by a return |
| cur_cs | input | 16 | Current code selector |
| cur_ip | input | OFF_W | Current instruction offset (return point) |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | OFF_W | Current stack offset |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_wide | output | 1 | 1: 4-byte transfer, 0: 2-byte |
| mem_seg | output | 16 | Segment selector of the access |
| mem_off | output | OFF_W | Byte offset of the access |
| mem_wdata | output | OFF_W | Write data |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| mem_rdata | input | OFF_W | Read data, valid with mem_ack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on the final register load |
| fault | output | 1 | One-cycle pulse on a rejected call |
| out_cs | output | 16 | Resulting code selector |
| out_ip | output | OFF_W | Resulting instruction offset |
| out_ss | output | 16 | Resulting stack selector |
| out_sp | output | OFF_W | Resulting stack offset |

## Verification
The call path is tried in three forms. The first is an inward 32-bit gate with two parameters and a 32-bit task-state segment. The second is an inward 16-bit gate with one parameter and a 16-bit task-state segment. The third is an inward call with zero parameters to ring 2. Together these separate the slot width, the task-state offset formula per ring and layout, and the parameter order. A same-level call with a nonzero count shows that neither the task-state read nor the copy happens. Each call is followed by its return: a 32-bit outer return with a discard, a 16-bit outer return, and a same-level return whose SP must land past the discard. The four fault causes are each tried alone, so that every term of the gate check is observed to leave the outputs unchanged with no memory traffic.

// File: rtl/gate_xfer_pkg.sv
package gate_xfer_pkg;
    localparam int GATE_W = 64;
    localparam int CNT_W  = 5;
    localparam int SEL_W  = 16;
    localparam logic [3:0] TYPE_GATE16 = 4'h4;
    localparam logic [3:0] TYPE_GATE32 = 4'hC;

    typedef enum logic [3:0] {
        S_IDLE, S_TSP, S_TSS, S_PSS, S_PSP, S_CRD, S_CWR,
        S_PCS, S_PIP, S_RIP, S_RCS, S_RSP, S_RSS, S_LOAD
    } state_e;
endpackage

// File: rtl/gx_gate_check.sv
module gx_gate_check
    import gate_xfer_pkg::*;
(
    input  logic [GATE_W-1:0] gate,
    input  logic [1:0]        cpl,
    input  logic [1:0]        tpl,
    output logic              ok,
    output logic              wide,
    output logic              same_lvl,
    output logic [CNT_W-1:0]  cnt,
    output logic [SEL_W-1:0]  sel,
    output logic [31:0]       entry
);
    logic [3:0] gtype;
    logic [1:0] dpl;
    logic       present;
    logic       type_ok;

    always_comb begin
        gtype    = gate[43:40];
        dpl      = gate[46:45];
        present  = gate[47];
        type_ok  = (gtype == TYPE_GATE16) || (gtype == TYPE_GATE32);
        wide     = (gtype == TYPE_GATE32);
        cnt      = gate[32 +: CNT_W];
        sel      = gate[31:16];
        entry    = {gate[63:48], gate[15:0]};
        same_lvl = (tpl == cpl);
        ok       = present && type_ok && (cpl <= dpl) && (tpl <= cpl);
    end
endmodule

// File: rtl/gx_tss_locate.sv
module gx_tss_locate #(
    parameter int OFF_W = 32
) (
    input  logic             wide,
    input  logic [1:0]       ring,
    output logic [OFF_W-1:0] sp_off,
    output logic [OFF_W-1:0] ss_off
);
    logic [OFF_W-1:0] ring_x;

    always_comb begin
        ring_x = OFF_W'(ring);
        if (wide) begin
            sp_off = OFF_W'(4) + (ring_x << 3);
            ss_off = OFF_W'(8) + (ring_x << 3);
        end else begin
            sp_off = OFF_W'(2) + (ring_x << 2);
            ss_off = OFF_W'(4) + (ring_x << 2);
        end
    end
endmodule

// File: rtl/gx_seq_core.sv
module gx_seq_core
    import gate_xfer_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic              chk_ok,
    input  logic              chk_wide,
    input  logic              chk_same,
    input  logic [CNT_W-1:0]  chk_cnt,
    input  logic [SEL_W-1:0]  chk_sel,
    input  logic [31:0]       chk_entry,
    input  logic [1:0]        tgt_pl,
    input  logic [SEL_W-1:0]  tss_sel,
    input  logic              tss_wide,
    input  logic              ret_wide,
    input  logic [15:0]       ret_bytes,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [OFF_W-1:0]  cur_ip,
    input  logic [SEL_W-1:0]  cur_ss,
    input  logic [OFF_W-1:0]  cur_sp,
    input  logic [OFF_W-1:0]  tss_sp_off,
    input  logic [OFF_W-1:0]  tss_ss_off,
    output logic              lat_tss_wide,
    output logic [1:0]        lat_tpl,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [SEL_W-1:0]  mem_seg,
    output logic [OFF_W-1:0]  mem_off,
    output logic [OFF_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [OFF_W-1:0]  mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [SEL_W-1:0]  out_cs,
    output logic [OFF_W-1:0]  out_ip,
    output logic [SEL_W-1:0]  out_ss,
    output logic [OFF_W-1:0]  out_sp
);
    typedef struct packed {
        state_e           state;
        logic             is_ret;
        logic             wide;
        logic             twide;
        logic [1:0]       tpl;
        logic [SEL_W-1:0] tsel;
        logic [SEL_W-1:0] sel;
        logic [SEL_W-1:0] cs_o;
        logic [SEL_W-1:0] ss_o;
        logic [SEL_W-1:0] css;
        logic [SEL_W-1:0] rcs;
        logic [CNT_W-1:0] k;
        logic [OFF_W-1:0] entry;
        logic [OFF_W-1:0] ip_o;
        logic [OFF_W-1:0] sp_o;
        logic [OFF_W-1:0] csp;
        logic [OFF_W-1:0] tmp;
        logic [OFF_W-1:0] rip;
        logic [15:0]      imm;
        logic [SEL_W-1:0] o_cs;
        logic [OFF_W-1:0] o_ip;
        logic [SEL_W-1:0] o_ss;
        logic [OFF_W-1:0] o_sp;
        logic             done;
        logic             fault;
    } seq_t;

    seq_t q, d;
    logic [OFF_W-1:0] slot;

    function automatic logic [OFF_W-1:0] trim(input logic [OFF_W-1:0] v, input logic w);
        return w ? v : OFF_W'(v[15:0]);
    endfunction

    assign slot = q.wide ? OFF_W'(4) : OFF_W'(2);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.fault = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (call_req) begin
                    if (!chk_ok) begin
                        d.fault = 1'b1;
                    end else begin
                        d.is_ret = 1'b0;
                        d.wide   = chk_wide;
                        d.twide  = tss_wide;
                        d.tpl    = tgt_pl;
                        d.tsel   = tss_sel;
                        d.k      = chk_cnt;
                        d.sel    = chk_sel;
                        d.entry  = chk_wide ? OFF_W'(chk_entry) : OFF_W'(chk_entry[15:0]);
                        d.cs_o   = cur_cs;
                        d.ip_o   = cur_ip;
                        d.ss_o   = cur_ss;
                        d.sp_o   = cur_sp;
                        d.css    = cur_ss;
                        d.csp    = cur_sp;
                        d.state  = chk_same ? S_PCS : S_TSP;
                    end
                end else if (ret_req) begin
                    d.is_ret = 1'b1;
                    d.wide   = ret_wide;
                    d.imm    = ret_bytes;
                    d.cs_o   = cur_cs;
                    d.css    = cur_ss;
                    d.csp    = cur_sp;
                    d.state  = S_RIP;
                end
            end
            S_TSP: if (mem_ack) begin
                d.csp   = trim(mem_rdata, q.twide);
                d.state = S_TSS;
            end
            S_TSS: if (mem_ack) begin
                d.css   = mem_rdata[SEL_W-1:0];
                d.state = S_PSS;
            end
            S_PSS: if (mem_ack) begin
                d.csp   = q.csp - slot;
                d.state = S_PSP;
            end
            S_PSP: if (mem_ack) begin
                d.csp   = q.csp - slot;
                d.state = (q.k == '0) ? S_PCS : S_CRD;
            end
            S_CRD: if (mem_ack) begin
                d.tmp   = trim(mem_rdata, q.wide);
                d.state = S_CWR;
            end
            S_CWR: if (mem_ack) begin
                d.csp   = q.csp - slot;
                d.k     = q.k - CNT_W'(1);
                d.state = (q.k == CNT_W'(1)) ? S_PCS : S_CRD;
            end
            S_PCS: if (mem_ack) begin
                d.csp   = q.csp - slot;
                d.state = S_PIP;
            end
            S_PIP: if (mem_ack) begin
                d.csp   = q.csp - slot;
                d.state = S_LOAD;
            end
            S_RIP: if (mem_ack) begin
                d.rip   = trim(mem_rdata, q.wide);
                d.csp   = q.csp + slot;
                d.state = S_RCS;
            end
            S_RCS: if (mem_ack) begin
                d.rcs   = mem_rdata[SEL_W-1:0];
                d.csp   = q.csp + slot + OFF_W'(q.imm);
                d.state = (mem_rdata[1:0] > q.cs_o[1:0]) ? S_RSP : S_LOAD;
            end
            S_RSP: if (mem_ack) begin
                d.tmp   = trim(mem_rdata, q.wide);
                d.csp   = q.csp + slot;
                d.state = S_RSS;
            end
            S_RSS: if (mem_ack) begin
                d.css   = mem_rdata[SEL_W-1:0];
                d.csp   = q.tmp;
                d.state = S_LOAD;
            end
            S_LOAD: begin
                d.o_cs  = q.is_ret ? q.rcs : {q.sel[SEL_W-1:2], q.tpl};
                d.o_ip  = q.is_ret ? q.rip : q.entry;
                d.o_ss  = q.css;
                d.o_sp  = q.csp;
                d.done  = 1'b1;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wide  = q.wide;
        mem_seg   = q.css;
        mem_off   = q.csp - slot;
        mem_wdata = '0;
        case (q.state)
            S_TSP: begin
                mem_req = 1'b1; mem_seg = q.tsel; mem_off = tss_sp_off; mem_wide = q.twide;
            end
            S_TSS: begin
                mem_req = 1'b1; mem_seg = q.tsel; mem_off = tss_ss_off; mem_wide = 1'b0;
            end
            S_PSS: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = OFF_W'(q.ss_o); end
            S_PSP: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = trim(q.sp_o, q.wide); end
            S_CRD: begin
                mem_req = 1'b1;
                mem_seg = q.ss_o;
                mem_off = q.sp_o + (OFF_W'(q.k - CNT_W'(1)) << (q.wide ? 2 : 1));
            end
            S_CWR: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = q.tmp; end
            S_PCS: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = OFF_W'(q.cs_o); end
            S_PIP: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = trim(q.ip_o, q.wide); end
            S_RIP, S_RCS, S_RSP, S_RSS: begin mem_req = 1'b1; mem_off = q.csp; end
            default: ;
        endcase
    end

    assign busy         = (q.state != S_IDLE);
    assign done         = q.done;
    assign fault        = q.fault;
    assign out_cs       = q.o_cs;
    assign out_ip       = q.o_ip;
    assign out_ss       = q.o_ss;
    assign out_sp       = q.o_sp;
    assign lat_tss_wide = q.twide;
    assign lat_tpl      = q.tpl;

    a_r2_fault_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (out_cs == $past(out_cs)) && (out_ip == $past(out_ip))
               && (out_ss == $past(out_ss)) && (out_sp == $past(out_sp)));
    a_r2_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !busy && !mem_req && !done);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy));
    a_r9_req_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_off) && $stable(mem_seg)
                                  && $stable(mem_we));
    a_r2_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault}));
endmodule

// File: rtl/gate_xfer_seq.sv
module gate_xfer_seq
    import gate_xfer_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic [GATE_W-1:0] gate_desc,
    input  logic [1:0]        tgt_pl,
    input  logic [SEL_W-1:0]  tss_sel,
    input  logic              tss_wide,
    input  logic              ret_wide,
    input  logic [15:0]       ret_bytes,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [OFF_W-1:0]  cur_ip,
    input  logic [SEL_W-1:0]  cur_ss,
    input  logic [OFF_W-1:0]  cur_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [SEL_W-1:0]  mem_seg,
    output logic [OFF_W-1:0]  mem_off,
    output logic [OFF_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [OFF_W-1:0]  mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [SEL_W-1:0]  out_cs,
    output logic [OFF_W-1:0]  out_ip,
    output logic [SEL_W-1:0]  out_ss,
    output logic [OFF_W-1:0]  out_sp
);
    logic             chk_ok, chk_wide, chk_same;
    logic [CNT_W-1:0] chk_cnt;
    logic [SEL_W-1:0] chk_sel;
    logic [31:0]      chk_entry;
    logic             lat_tss_wide;
    logic [1:0]       lat_tpl;
    logic [OFF_W-1:0] tss_sp_off, tss_ss_off;

    gx_gate_check u_check (
        .gate(gate_desc), .cpl(cur_cs[1:0]), .tpl(tgt_pl),
        .ok(chk_ok), .wide(chk_wide), .same_lvl(chk_same),
        .cnt(chk_cnt), .sel(chk_sel), .entry(chk_entry)
    );

    gx_tss_locate #(.OFF_W(OFF_W)) u_tss (
        .wide(lat_tss_wide), .ring(lat_tpl),
        .sp_off(tss_sp_off), .ss_off(tss_ss_off)
    );

    gx_seq_core #(.OFF_W(OFF_W)) u_core (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
        .chk_ok(chk_ok), .chk_wide(chk_wide), .chk_same(chk_same),
        .chk_cnt(chk_cnt), .chk_sel(chk_sel), .chk_entry(chk_entry),
        .tgt_pl(tgt_pl), .tss_sel(tss_sel), .tss_wide(tss_wide),
        .ret_wide(ret_wide), .ret_bytes(ret_bytes),
        .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_sp(cur_sp),
        .tss_sp_off(tss_sp_off), .tss_ss_off(tss_ss_off),
        .lat_tss_wide(lat_tss_wide), .lat_tpl(lat_tpl),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_seg(mem_seg), .mem_off(mem_off), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault(fault),
        .out_cs(out_cs), .out_ip(out_ip), .out_ss(out_ss), .out_sp(out_sp)
    );
endmodule

// File: tb/tb_gate_xfer_seq.sv
module tb_gate_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0, ret_req = 1'b0;
    logic [63:0] gate_desc = '0;
    logic [1:0]  tgt_pl = '0;
    logic [15:0] tss_sel = '0;
    logic        tss_wide = 1'b0, ret_wide = 1'b0;
    logic [15:0] ret_bytes = '0;
    logic [15:0] cur_cs = '0, cur_ss = '0;
    logic [31:0] cur_ip = '0, cur_sp = '0;
    logic        mem_req, mem_we, mem_wide;
    logic [15:0] mem_seg;
    logic [31:0] mem_off, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, fault;
    logic [15:0] out_cs, out_ss;
    logic [31:0] out_ip, out_sp;

    int checks = 0, errors = 0, nacc = 0, wcnt = 0, lat = 0;
    logic [7:0] mem [0:4095];

    always #4 clk = ~clk;

    gate_xfer_seq dut (.*);

    typedef struct packed {
        logic        is_ret;
        logic [63:0] gate;
        logic [1:0]  tpl;
        logic [15:0] tsel;
        logic        twide;
        logic        rwide;
        logic [15:0] rb;
        logic [15:0] cs;
        logic [31:0] ip;
        logic [15:0] ss;
        logic [31:0] sp;
        logic        efault;
        logic [15:0] ecs;
        logic [31:0] eip;
        logic [15:0] ess;
        logic [31:0] esp;
        logic [7:0]  enacc;
    } vec_t;

    function automatic logic [63:0] mkg(input logic [31:0] off, input logic [15:0] sel,
                                        input logic p, input logic [1:0] dpl,
                                        input logic [3:0] typ, input logic [4:0] cnt);
        return {off[31:16], p, dpl, 1'b0, typ, 3'b000, cnt, sel, off[15:0]};
    endfunction

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{1'b0, mkg(32'h12345678, 16'h0040, 1'b1, 2'd3, 4'hC, 5'd2), 2'd0, 16'h0011, 1'b1, 1'b0, 16'd0,
          16'h0023, 32'h1234, 16'h0027, 32'hC0, 1'b0, 16'h0040, 32'h12345678, 16'h0018, 32'hD8, 8'd10},
        '{1'b1, 64'd0, 2'd0, 16'h0000, 1'b0, 1'b1, 16'd8,
          16'h0040, 32'h12345678, 16'h0018, 32'hD8, 1'b0, 16'h0023, 32'h1234, 16'h0027, 32'hC0, 8'd4},
        '{1'b0, mkg(32'hABCD9876, 16'h0050, 1'b1, 2'd3, 4'h4, 5'd1), 2'd1, 16'h0012, 1'b0, 1'b0, 16'd0,
          16'h0023, 32'h4444, 16'h0027, 32'h60, 1'b0, 16'h0051, 32'h9876, 16'h0029, 32'h96, 8'd8},
        '{1'b1, 64'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 16'd2,
          16'h0051, 32'h9876, 16'h0029, 32'h96, 1'b0, 16'h0023, 32'h4444, 16'h0027, 32'h60, 8'd4},
        '{1'b0, mkg(32'h00002000, 16'h0060, 1'b1, 2'd1, 4'hC, 5'd3), 2'd1, 16'h0011, 1'b1, 1'b0, 16'd0,
          16'h0009, 32'h777, 16'h0029, 32'h80, 1'b0, 16'h0061, 32'h2000, 16'h0029, 32'h78, 8'd2},
        '{1'b1, 64'd0, 2'd0, 16'h0000, 1'b0, 1'b1, 16'd4,
          16'h0061, 32'h2000, 16'h0029, 32'h78, 1'b0, 16'h0009, 32'h777, 16'h0029, 32'h84, 8'd2},
        '{1'b0, mkg(32'h00003000, 16'h0070, 1'b1, 2'd3, 4'hC, 5'd0), 2'd2, 16'h0011, 1'b1, 1'b0, 16'd0,
          16'h0023, 32'h55, 16'h0027, 32'h40, 1'b0, 16'h0072, 32'h3000, 16'h003A, 32'h40, 8'd6},
        '{1'b0, mkg(32'h100, 16'h0040, 1'b1, 2'd3, 4'h5, 5'd0), 2'd0, 16'h0011, 1'b1, 1'b0, 16'd0,
          16'h0023, 32'h55, 16'h0027, 32'h40, 1'b1, 16'h0072, 32'h3000, 16'h003A, 32'h40, 8'd0},
        '{1'b0, mkg(32'h100, 16'h0040, 1'b0, 2'd3, 4'hC, 5'd0), 2'd0, 16'h0011, 1'b1, 1'b0, 16'd0,
          16'h0023, 32'h55, 16'h0027, 32'h40, 1'b1, 16'h0072, 32'h3000, 16'h003A, 32'h40, 8'd0},
        '{1'b0, mkg(32'h100, 16'h0040, 1'b1, 2'd2, 4'hC, 5'd0), 2'd0, 16'h0011, 1'b1, 1'b0, 16'd0,
          16'h0023, 32'h55, 16'h0027, 32'h40, 1'b1, 16'h0072, 32'h3000, 16'h003A, 32'h40, 8'd0},
        '{1'b0, mkg(32'h100, 16'h0040, 1'b1, 2'd3, 4'h4, 5'd0), 2'd2, 16'h0011, 1'b1, 1'b0, 16'd0,
          16'h0009, 32'h55, 16'h0027, 32'h40, 1'b1, 16'h0072, 32'h3000, 16'h003A, 32'h40, 8'd0}
    };

    function automatic int idx(input logic [15:0] seg, input logic [31:0] off);
        return int'({seg[3:0], off[7:0]});
    endfunction

    task automatic put(input logic [15:0] seg, input logic [31:0] off, input logic [31:0] v, input int nb);
        for (int i = 0; i < nb; i++) mem[(idx(seg, off) + i) % 4096] = v[8*i +: 8];
    endtask

    function automatic logic [31:0] get(input logic [15:0] seg, input logic [31:0] off, input int nb);
        logic [31:0] r = '0;
        for (int i = 0; i < nb; i++) r[8*i +: 8] = mem[(idx(seg, off) + i) % 4096];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            if (wcnt < lat) wcnt++;
            else begin
                if (mem_we) put(mem_seg, mem_off, mem_wdata, mem_wide ? 4 : 2);
                else mem_rdata = get(mem_seg, mem_off, mem_wide ? 4 : 2);
                mem_ack = 1'b1;
                nacc++;
                wcnt = 0;
                lat = (lat == 2) ? 0 : lat + 1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic run_vec(input vec_t v, input string tag);
        int n;
        gate_desc = v.gate; tgt_pl = v.tpl; tss_sel = v.tsel; tss_wide = v.twide;
        ret_wide = v.rwide; ret_bytes = v.rb;
        cur_cs = v.cs; cur_ip = v.ip; cur_ss = v.ss; cur_sp = v.sp;
        nacc = 0;
        if (v.is_ret) ret_req = 1'b1; else call_req = 1'b1;
        @(negedge clk);
        call_req = 1'b0; ret_req = 1'b0;
        if (v.efault) begin
            chk({tag, " fault pulse"}, 32'(fault), 32'd1);
            chk({tag, " fault not busy"}, 32'(busy), 32'd0);
        end else begin
            chk({tag, " R9 busy after request"}, 32'(busy), 32'd1);
            n = 0;
            while (!done && n < 400) begin
                if (!busy) chk({tag, " R9 busy held"}, 32'(busy), 32'd1);
                @(negedge clk);
                n++;
            end
            chk({tag, " R9 done seen"}, 32'(done), 32'd1);
            chk({tag, " R9 busy low at done"}, 32'(busy), 32'd0);
        end
        chk({tag, " cs"}, 32'(out_cs), 32'(v.ecs));
        chk({tag, " ip"}, out_ip, v.eip);
        chk({tag, " ss"}, 32'(out_ss), 32'(v.ess));
        chk({tag, " sp"}, out_sp, v.esp);
        chk({tag, " memory accesses"}, 32'(nacc), 32'(v.enacc));
        @(negedge clk);
        chk({tag, " R9 single-cycle pulse"}, 32'({done, fault}), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        put(16'h0011, 32'd4,  32'h000000F0, 4);
        put(16'h0011, 32'd8,  32'h00000018, 2);
        put(16'h0011, 32'd20, 32'h00000050, 4);
        put(16'h0011, 32'd24, 32'h0000003A, 2);
        put(16'h0012, 32'd6,  32'h000000A0, 2);
        put(16'h0012, 32'd8,  32'h00000029, 2);
        put(16'h0027, 32'hC0, 32'hAAAA0001, 4);
        put(16'h0027, 32'hC4, 32'hBBBB0002, 4);
        put(16'h0027, 32'h60, 32'h00005A5A, 2);

        repeat (3) @(negedge clk);
        chk("reset outputs cs/ss", {out_cs, out_ss}, 32'd0);
        chk("reset outputs ip", out_ip, 32'd0);
        chk("reset outputs sp", out_sp, 32'd0);
        chk("reset R9 busy/done/fault/req", 32'({busy, done, fault, mem_req}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            if (TBL[i].efault) tag = $sformatf("R2 vec%0d", i);
            else if (TBL[i].is_ret) tag = $sformatf("R8 vec%0d", i);
            else if (TBL[i].tpl == TBL[i].cs[1:0]) tag = $sformatf("R7 vec%0d", i);
            else tag = $sformatf("R1 R3 R6 vec%0d", i);
            run_vec(TBL[i], tag);
        end

        chk("R4 old SS pushed on new stack", get(16'h0018, 32'hEC, 4), 32'h00000027);
        chk("R4 old SP pushed on new stack", get(16'h0018, 32'hE8, 4), 32'h000000C0);
        chk("R5 first parameter copied", get(16'h0018, 32'hE0, 4), 32'hAAAA0001);
        chk("R5 second parameter copied", get(16'h0018, 32'hE4, 4), 32'hBBBB0002);
        chk("R4 return CS pushed", get(16'h0018, 32'hDC, 4), 32'h00000023);
        chk("R4 return IP pushed", get(16'h0018, 32'hD8, 4), 32'h00001234);
        chk("R4 16-bit SS slot", get(16'h0029, 32'h9E, 2), 32'h00000027);
        chk("R5 16-bit parameter copied", get(16'h0029, 32'h9A, 2), 32'h00005A5A);
        chk("R4 16-bit IP slot", get(16'h0029, 32'h96, 2), 32'h00004444);
        chk("R7 same-level CS push", get(16'h0029, 32'h7C, 4), 32'h00000009);
        chk("R3 ring2 frame SS push", get(16'h003A, 32'h4C, 4), 32'h00000027);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule